// File: doc/BRIEF.md
# Serial register-access slave

This block lets an external two-wire bus master read and write a local file of 256 eight-bit registers. The bus clock and data lines enter as plain inputs and are oversampled by a much faster system clock. The block finds start and stop conditions in the sampled waveform, compares the header byte against its own 7-bit device address, and then runs the register protocol. In that protocol the first byte of a write selects a register pointer, and later bytes are stored at the pointer with automatic increment. Reads stream register contents out most significant bit first.

The slave never drives the data line high. Its single output is an open-drain pull-down enable that the pad logic turns into a low drive. The internal pointer always holds one more than the last location touched. This makes a bare read header continue where the last access stopped. A write header followed by only a pointer byte and then a repeated start acts as a pure pointer load for a random read.

Top module: `sreg_slave`

## Requirements
- R1: While reset is asserted and after it is released, sda_oe_o is 0, the pointer is 0x00 and every register reads back as 0x00.
- R2: A start (data falling while clock is high) seen in any state, including partway through a byte, abandons that byte without storing it and returns to header reception. A stop (data rising while clock is high) returns to idle with sda_oe_o low. In both cases the pointer keeps the last value it was given.
- R3: Bits 7:1 of the first byte after a start are compared with the device address (default 0x69), and bit 0 selects the direction (1 = read, 0 = write). On a mismatch the slave gives no acknowledge, never drives the line, and stores nothing until the next start or stop.
- R4: The slave holds the line low (sda_oe_o = 1) for the whole ninth clock of a matching header, of the pointer byte and of every written data byte.
- R5: The first byte after a write header loads the pointer. Each later byte is stored at the pointer, and the pointer then increments.
- R6: The pointer wraps from 0xFF to 0x00 on both writes and reads.
- R7: After an access to location n the pointer holds n+1. A read header that has no pointer byte before it returns the register at the pointer, MSB first.
- R8: A repeated start right after an acknowledged pointer byte leaves the pointer loaded and stores no data. The read that follows starts at that location.
- R9: If the master acknowledges (line low in the ninth clock), the next location is sent. If it does not, the slave releases the line, sends nothing more (the line reads 1) and does not advance the pointer again until a start or stop.
- R10: sda_oe_o changes only shortly after a falling clock edge, or on a start or stop. It never changes during a clock high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the bus bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND value) |
| sda_oe_o | output | 1 | Pull-down enable for the data pad; 1 drives the line low |

## Verification
A bus edge reaches the protocol engine after two synchronizer flops and one edge register. So sda_oe_o moves on the third system clock after the pad-level clock fall that triggers it. The bench holds every quarter of a bus bit for ten system clocks and samples the wired line in the middle of the high phase. Acknowledge bits and read-data bits are therefore read at least seven cycles after they are due. Edge placement (R10) is checked by a monitor that flags any change of sda_oe_o while the bench is holding the clock high.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

   // Events extracted from the oversampled bus, one system clock wide
   typedef struct packed {
      logic sda;    // synchronized data level
      logic rise;   // clock rising edge
      logic fall;   // clock falling edge
      logic start;  // data fell while clock high
      logic stop;   // data rose while clock high
   } bus_evt_t;

   typedef enum logic [3:0] {
      S_IDLE,
      S_HDR,    // receiving address + direction byte
      S_HACK,   // acknowledging header
      S_PTR,    // receiving pointer byte
      S_PACK,   // acknowledging pointer
      S_WDAT,   // receiving write data
      S_WACK,   // acknowledging write data
      S_TX,     // transmitting read data
      S_MACK,   // sampling master acknowledge
      S_IGN     // not addressed / finished, wait for start or stop
   } link_state_t;

endpackage

// File: rtl/sreg_sampler.sv
module sreg_sampler
   import sreg_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_i,
   input  logic     sda_i,
   output bus_evt_t evt
);

   generate
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] scl_q, sda_q;
   logic                   scl_prev, sda_prev;
   logic                   scl_s, sda_s;

   // idle bus is high, so reset to 1 to avoid a phantom start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q    <= '1;
         sda_q    <= '1;
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_q    <= {scl_q[SYNC_STAGES-2:0], scl_i};
         sda_q    <= {sda_q[SYNC_STAGES-2:0], sda_i};
         scl_prev <= scl_s;
         sda_prev <= sda_s;
      end
   end

   assign scl_s = scl_q[SYNC_STAGES-1];
   assign sda_s = sda_q[SYNC_STAGES-1];

   always_comb begin
      evt.sda   = sda_s;
      evt.rise  = scl_s & ~scl_prev;
      evt.fall  = ~scl_s & scl_prev;
      evt.start = scl_s & scl_prev & sda_prev & ~sda_s;
      evt.stop  = scl_s & scl_prev & ~sda_prev & sda_s;
   end

endmodule

// File: rtl/sreg_regfile.sv
module sreg_regfile #(
   parameter int PTR_W  = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [PTR_W-1:0]  addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << PTR_W;

   generate
      if (DEPTH > 4096) begin : g_chk_depth
         $error("register file too deep for flop storage");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[addr] <= wdata;
      end
   end

   assign rdata = mem[addr];

   // R5: a strobed byte is present at its location on the next clock
   p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem[$past(addr)] == $past(wdata));

endmodule

// File: rtl/sreg_engine.sv
module sreg_engine
   import sreg_pkg::*;
#(
   parameter int         PTR_W    = 8,
   parameter int         DATA_W   = 8,
   parameter logic [6:0] DEV_ADDR = 7'h69
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_evt_t          evt,
   input  logic [DATA_W-1:0] rd_data,
   output logic [PTR_W-1:0]  ptr_o,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic              sda_oe
);

   localparam int                CNT_W    = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
   localparam logic [PTR_W-1:0]  PTR_ONE  = PTR_W'(1);

   generate
      if (DATA_W != 8) begin : g_chk_data
         $error("bus protocol carries 8-bit bytes only");
      end
      if (PTR_W < 1 || PTR_W > DATA_W) begin : g_chk_ptr
         $error("pointer must fit in one byte");
      end
   endgenerate

   link_state_t       state;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] rx_sh, tx_sh;
   logic [PTR_W-1:0]  ptr;
   logic              rw, mack;

   wire byte_done = evt.fall && (cnt == LAST_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         cnt    <= '0;
         rx_sh  <= '0;
         tx_sh  <= '0;
         ptr    <= '0;
         rw     <= 1'b0;
         mack   <= 1'b0;
         sda_oe <= 1'b0;
      end else if (evt.stop) begin
         state  <= S_IDLE;
         cnt    <= '0;
         sda_oe <= 1'b0;
      end else if (evt.start) begin
         state  <= S_HDR;
         cnt    <= '0;
         sda_oe <= 1'b0;
      end else begin
         case (state)
            S_HDR, S_PTR, S_WDAT: begin
               if (evt.rise) begin
                  rx_sh <= {rx_sh[DATA_W-2:0], evt.sda};
                  cnt   <= cnt + CNT_ONE;
               end else if (byte_done) begin
                  cnt <= '0;
                  if (state == S_HDR) begin
                     if (rx_sh[7:1] == DEV_ADDR) begin
                        sda_oe <= 1'b1;
                        rw     <= rx_sh[0];
                        state  <= S_HACK;
                     end else begin
                        state  <= S_IGN;
                     end
                  end else if (state == S_PTR) begin
                     ptr    <= rx_sh[PTR_W-1:0];
                     sda_oe <= 1'b1;
                     state  <= S_PACK;
                  end else begin
                     ptr    <= ptr + PTR_ONE;
                     sda_oe <= 1'b1;
                     state  <= S_WACK;
                  end
               end
            end
            S_HACK, S_PACK, S_WACK: begin
               if (evt.fall) begin
                  if (state == S_HACK && rw) begin
                     tx_sh  <= rd_data;
                     sda_oe <= ~rd_data[DATA_W-1];
                     ptr    <= ptr + PTR_ONE;
                     state  <= S_TX;
                  end else begin
                     sda_oe <= 1'b0;
                     state  <= (state == S_HACK) ? S_PTR : S_WDAT;
                  end
               end
            end
            S_TX: begin
               if (evt.rise) begin
                  cnt <= cnt + CNT_ONE;
               end else if (byte_done) begin
                  cnt    <= '0;
                  sda_oe <= 1'b0;
                  state  <= S_MACK;
               end else if (evt.fall) begin
                  tx_sh  <= {tx_sh[DATA_W-2:0], 1'b0};
                  sda_oe <= ~tx_sh[DATA_W-2];
               end
            end
            S_MACK: begin
               if (evt.rise) begin
                  mack <= ~evt.sda;
               end else if (evt.fall) begin
                  if (mack) begin
                     tx_sh  <= rd_data;
                     sda_oe <= ~rd_data[DATA_W-1];
                     ptr    <= ptr + PTR_ONE;
                     state  <= S_TX;
                  end else begin
                     state  <= S_IGN;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign wr_en   = (state == S_WDAT) && byte_done;
   assign wr_data = rx_sh;
   assign ptr_o   = ptr;

   // R2: a start always lands in header reception
   p_start_to_hdr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      evt.start |=> (state == S_HDR));

   // R2: a stop always releases the line and idles
   p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
      evt.stop |=> (state == S_IDLE) && !sda_oe);

   // R3: an unaddressed slave keeps off the line
   p_ign_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IGN) |-> !sda_oe);

   // R5: each stored byte advances the pointer by one (R6 wraps modulo)
   p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ptr == $past(ptr) + PTR_ONE);

   // R10: the pull-down only moves after a clock fall or a start/stop
   p_oe_after_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> $past(evt.fall || evt.start || evt.stop));

endmodule

// File: rtl/sreg_slave.sv
module sreg_slave
   import sreg_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter int         PTR_W       = 8,
   parameter int         DATA_W      = 8,
   parameter logic [6:0] DEV_ADDR    = 7'h69
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe_o
);

   bus_evt_t          evt;
   logic [PTR_W-1:0]  ptr;
   logic              wr_en;
   logic [DATA_W-1:0] wr_data, rd_data;

   sreg_sampler #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_sampler (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_i (scl_i),
      .sda_i (sda_i),
      .evt   (evt)
   );

   sreg_engine #(
      .PTR_W    (PTR_W),
      .DATA_W   (DATA_W),
      .DEV_ADDR (DEV_ADDR)
   ) u_engine (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt),
      .rd_data (rd_data),
      .ptr_o   (ptr),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .sda_oe  (sda_oe_o)
   );

   sreg_regfile #(
      .PTR_W  (PTR_W),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en),
      .addr  (ptr),
      .wdata (wr_data),
      .rdata (rd_data)
   );

endmodule

// File: tb/tb_sreg_slave.sv
module tb_sreg_slave;

   localparam int         Q      = 10;        // system clocks per quarter bit
   localparam logic [6:0] DEV    = 7'h69;
   localparam int         WD_MAX = 190000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic sda_oe;
   logic sda_line;

   always #10 clk = ~clk;   // 50 MHz

   assign sda_line = m_sda & ~sda_oe;

   sreg_slave dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (m_scl),
      .sda_i    (sda_line),
      .sda_oe_o (sda_oe)
   );

   int checks = 0;
   int fails  = 0;
   int oe_violations = 0;
   bit done = 1'b0;
   logic [7:0] model [256];
   logic [7:0] exp_ptr;
   logic [7:0] wbuf [8];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_byte(input logic [7:0] p);
      return model[p];
   endfunction

   // R10 monitor: no pull-down change while the clock is held high
   logic prev_scl = 1'b1;
   logic prev_oe  = 1'b0;
   always @(negedge clk) begin
      if (rst_n && m_scl && prev_scl && (sda_oe !== prev_oe)) oe_violations++;
      prev_scl <= m_scl;
      prev_oe  <= sda_oe;
   end

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; wq();
      m_scl = 1'b1; wq();
      m_sda = 1'b0; wq();
      m_scl = 1'b0; wq();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wq();
      m_scl = 1'b1; wq();
      m_sda = 1'b1; wq();
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         m_sda = b[i]; wq();
         m_scl = 1'b1; wq(); wq();
         m_scl = 1'b0; wq();
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      send_bits(b, 8);
      m_sda = 1'b1; wq();
      m_scl = 1'b1; wq();
      ack = (sda_line == 1'b0);
      wq();
      m_scl = 1'b0; wq();
   endtask

   task automatic recv_byte(input bit give_ack, output logic [7:0] b);
      b = '0;
      for (int i = 0; i < 8; i++) begin
         m_sda = 1'b1; wq();
         m_scl = 1'b1; wq();
         b = {b[6:0], sda_line};
         wq();
         m_scl = 1'b0; wq();
      end
      m_sda = give_ack ? 1'b0 : 1'b1; wq();
      m_scl = 1'b1; wq(); wq();
      m_scl = 1'b0; wq();
      m_sda = 1'b1;
   endtask

   // pointer byte then n data bytes from wbuf
   task automatic wr_seq(input logic [7:0] p, input int n);
      bit ack;
      bus_start();
      send_byte({DEV, 1'b0}, ack); chk(ack, "R4 header ack", ack, 1);
      send_byte(p, ack);           chk(ack, "R4 pointer ack", ack, 1);
      exp_ptr = p;
      for (int k = 0; k < n; k++) begin
         send_byte(wbuf[k], ack);  chk(ack, "R4 data ack", ack, 1);
         model[exp_ptr] = wbuf[k];
         exp_ptr = exp_ptr + 8'd1;
      end
      bus_stop();
   endtask

   // optional pointer load with repeated start, then n reads
   task automatic rd_seq(input bit set_ptr, input logic [7:0] p, input int n, input string tag);
      bit ack;
      logic [7:0] b;
      bus_start();
      if (set_ptr) begin
         send_byte({DEV, 1'b0}, ack); chk(ack, "R4 header ack", ack, 1);
         send_byte(p, ack);           chk(ack, "R4 pointer ack", ack, 1);
         exp_ptr = p;
         bus_start();
      end
      send_byte({DEV, 1'b1}, ack); chk(ack, "R3 read header ack", ack, 1);
      for (int k = 0; k < n; k++) begin
         recv_byte(k != n - 1, b);
         chk(b == exp_byte(exp_ptr), tag, b, exp_byte(exp_ptr));
         exp_ptr = exp_ptr + 8'd1;
      end
      bus_stop();
   endtask

   initial begin
      repeat (WD_MAX) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog all-reqs actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      bit ack;
      logic [7:0] b;
      for (int i = 0; i < 256; i++) model[i] = 8'h00;
      exp_ptr = 8'h00;
      void'($urandom(32'd2024));

      repeat (5) @(negedge clk);
      chk(sda_oe == 1'b0, "R1 oe in reset", sda_oe, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);

      // R1: pointer starts at 0 and registers are clear
      rd_seq(1'b0, 8'h00, 2, "R1 reset read");
      rd_seq(1'b1, 8'hC3, 2, "R1 reset read far");

      // R5 single write and random readback (R8)
      wbuf[0] = 8'hA5;
      wr_seq(8'h10, 1);
      rd_seq(1'b1, 8'h10, 1, "R8 random read");

      // R6 burst across the top of the file
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
      wr_seq(8'hFE, 4);
      rd_seq(1'b0, 8'h00, 1, "R7 current after write");   // reads 0x02
      rd_seq(1'b1, 8'hFE, 4, "R6 R9 sequential wrap");
      rd_seq(1'b0, 8'h00, 1, "R7 current after read");    // reads 0x02

      // R8 repeated start after pointer stores nothing
      wbuf[0] = 8'h77;
      wr_seq(8'h40, 1);
      rd_seq(1'b1, 8'h40, 1, "R8 pointer-only write");

      // R2 start in mid byte: byte discarded, pointer kept
      bus_start();
      send_byte({DEV, 1'b0}, ack); chk(ack, "R4 header ack", ack, 1);
      send_byte(8'h40, ack);       chk(ack, "R4 pointer ack", ack, 1);
      send_bits(8'h00, 4);
      bus_start();
      send_byte({DEV, 1'b1}, ack); chk(ack, "R2 header after abort", ack, 1);
      recv_byte(1'b0, b);
      chk(b == 8'h77, "R2 start abort", b, 8'h77);
      bus_stop();

      // R2 stop in mid byte
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'h40, ack);
      send_bits(8'h00, 3);
      bus_stop();
      exp_ptr = 8'h40;
      rd_seq(1'b0, 8'h00, 1, "R2 stop abort");

      // R3 wrong address: no ack, nothing stored, line undriven
      bus_start();
      send_byte({7'h6A, 1'b0}, ack); chk(!ack, "R3 foreign header nack", ack, 0);
      send_byte(8'h10, ack);         chk(!ack, "R3 foreign pointer nack", ack, 0);
      send_byte(8'h5A, ack);         chk(!ack, "R3 foreign data nack", ack, 0);
      bus_stop();
      bus_start();
      send_byte({7'h68, 1'b1}, ack); chk(!ack, "R3 foreign read nack", ack, 0);
      recv_byte(1'b0, b);            chk(b == 8'hFF, "R3 foreign read idle", b, 8'hFF);
      bus_stop();
      rd_seq(1'b1, 8'h10, 1, "R3 location untouched");

      // R9 nack releases the line and freezes the pointer
      bus_start();
      send_byte({DEV, 1'b1}, ack); chk(ack, "R9 header ack", ack, 1);
      recv_byte(1'b0, b);
      chk(b == exp_byte(exp_ptr), "R9 first byte", b, exp_byte(exp_ptr));
      exp_ptr = exp_ptr + 8'd1;
      recv_byte(1'b0, b);
      chk(b == 8'hFF, "R9 released after nack", b, 8'hFF);
      bus_stop();
      rd_seq(1'b0, 8'h00, 1, "R9 pointer frozen");

      // constrained random traffic
      for (int it = 0; it < 24; it++) begin
         int op;
         int n;
         logic [7:0] p;
         op = int'($urandom % 3);
         n  = 1 + int'($urandom % 4);
         p  = (($urandom % 4) == 0) ? 8'hFC + 8'($urandom % 4) : 8'($urandom);
         if (op == 0) begin
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            wr_seq(p, n);
         end else if (op == 1) begin
            rd_seq(1'b1, p, n, "R9 random sequential");
         end else begin
            rd_seq(1'b0, 8'h00, n, "R7 random current");
         end
      end

      chk(oe_violations == 0, "R10 oe moved in high phase", oe_violations, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule